// File: doc/BRIEF.md
# Ring-Checked Address-Space TLB Lookup

This block is the lookup and fill part of a software-managed translation buffer. It holds two independent arrays, one for instruction fetches and one for data accesses. Each array has several ways of a few entries each. An entry carries a virtual page number, a physical page number, an 8-bit address-space identifier (ASID) and a 4-bit attribute. A lookup presents a 32-bit virtual address and a side select. All ways of that side are compared in parallel in the same cycle. The result is the hitting way, the entry index, the privilege ring, the physical page, the attribute and a cause code.

Entries do not store a privilege ring. A 32-bit ring-ASID register holds one ASID byte for each of rings 0 to 3, and the ring of a hit is recovered by matching the entry's ASID against those bytes. The register can be written at any time, which remaps the rings of existing entries at once. Software fills entries through a synchronous write port. The way is taken from the low bits of the write operand, and the page and index come from its upper bits. The entry's ASID is copied from the ring-ASID byte that the write names.

Top module: `asid_tlb_lookup`

## Requirements
- R1: After reset every entry's ASID is 0, so every lookup misses. The ring-ASID register reads 0x04030201, so an entry written with ring k (0..3) takes ASID k+1 and reports ring k.
- R2: A write to the ring-ASID register stores bits [31:8] as given and forces bits [7:0] to 0x01. Ring 0 therefore always owns ASID 1, even when the written low byte is 0.
- R3: An entry whose ASID is 0 never produces a hit, whatever its page number.
- R4: The entry index is lk_va[13:12] and the compared page number is lk_va[31:12]. A way hits when its entry at that index has an equal page number and a non-zero ASID. On a hit, lk_way, lk_index, lk_ppn and lk_attr come from that entry.
- R5: The ring of a hit is the lowest ring i whose byte lk_ring-ASID[8i+7:8i] equals the entry ASID. When no byte matches, the ring is 3.
- R6: A hit in two or more ways gives cause low bits 2'b10 (multi-hit). The reported way and its fields are those of the lowest-numbered hitting way.
- R7: No hitting way gives cause low bits 2'b01 (miss). On a miss lk_way, lk_index, lk_ring, lk_ppn and lk_attr are all 0.
- R8: lk_cause is 3'b000 on a single hit. For a miss or a multi-hit, bit 2 equals lk_data, which gives separate instruction (1, 2) and data (5, 6) codes.
- R9: For a data write the way is wr_sel[3:0]. For an instruction write it is wr_sel[2:0], and wr_sel[3] is ignored. A way number of NWAYS or more leaves the arrays unchanged.
- R10: A write loads the entry at wr_sel[13:12] with page number wr_sel[31:12], wr_ppn, wr_attr and the ASID byte of ring wr_ring, taken from the register value before any ring-ASID write in the same cycle. A lookup in the next cycle sees the new entry.
- R11: The instruction and data arrays are separate. A write to one side never changes lookups on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_data | input | 1 | Lookup side: 1 data, 0 instruction |
| lk_way | output | 4 | Hitting way (lowest on multi-hit), 0 on miss |
| lk_index | output | IDX_W | Entry index of the hit, 0 on miss |
| lk_ring | output | 2 | Ring recovered from the ring-ASID register |
| lk_cause | output | 3 | 0 hit, {lk_data,01} miss, {lk_data,10} multi-hit |
| lk_ppn | output | 32-PAGE_SHIFT | Physical page number of the hit |
| lk_attr | output | 4 | Attribute of the hit |
| wr_en | input | 1 | Entry write strobe |
| wr_data | input | 1 | Write side: 1 data, 0 instruction |
| wr_sel | input | 32 | Page number, index and way select of the write |
| wr_ppn | input | 32-PAGE_SHIFT | Physical page number to store |
| wr_ring | input | 2 | Ring whose ASID byte is stored in the entry |
| wr_attr | input | 4 | Attribute to store |
| rasid_we | input | 1 | Ring-ASID register write strobe |
| rasid_wdata | input | 32 | Ring-ASID register write value |

## Verification
A corrupted entry or a misdirected write shows up on the lookup issued in the cycle after that write. It appears as a wrong way, a miss where a hit is due, or a missing multi-hit cause. The ring-ASID register is not a port, so a wrong value in it shows only through lk_ring, or through the ASID that a later write copies from it. A lost forcing of its low byte shows up as a miss on an entry written with ring 0. A wrong ring-priority order shows only when two bytes of the register hold the same ASID, so the stimulus writes repeated and zero bytes on purpose.

// File: rtl/asid_tlb_lookup.sv
module asid_tlb_lookup #(
  parameter int NWAYS       = 4,
  parameter int IDX_W       = 2,
  parameter int PAGE_SHIFT  = 12,
  parameter logic [31:0] RASID_RESET = 32'h0403_0201
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [31:0]             lk_va,
  input  logic                    lk_data,
  output logic [3:0]              lk_way,
  output logic [IDX_W-1:0]        lk_index,
  output logic [1:0]              lk_ring,
  output logic [2:0]              lk_cause,
  output logic [31-PAGE_SHIFT:0]  lk_ppn,
  output logic [3:0]              lk_attr,
  input  logic                    wr_en,
  input  logic                    wr_data,
  input  logic [31:0]             wr_sel,
  input  logic [31-PAGE_SHIFT:0]  wr_ppn,
  input  logic [1:0]              wr_ring,
  input  logic [3:0]              wr_attr,
  input  logic                    rasid_we,
  input  logic [31:0]             rasid_wdata
);
  localparam int VPN_W  = 32 - PAGE_SHIFT;
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int SLOT_W = 1 + WAY_W + IDX_W;
  localparam int NSLOT  = 1 << SLOT_W;

  logic [VPN_W-1:0] vpn_q  [NSLOT];
  logic [VPN_W-1:0] ppn_q  [NSLOT];
  logic [7:0]       asid_q [NSLOT];
  logic [3:0]       attr_q [NSLOT];
  logic [31:0]      rasid_q;

  // write side
  logic [3:0]        wsel_way;
  logic              wsel_ok;
  logic [SLOT_W-1:0] wslot;
  logic [7:0]        wasid;

  assign wsel_way = wr_data ? wr_sel[3:0] : {1'b0, wr_sel[2:0]};
  assign wsel_ok  = wr_en && (int'(wsel_way) < NWAYS);
  assign wslot    = {wr_data, wsel_way[WAY_W-1:0], wr_sel[PAGE_SHIFT +: IDX_W]};
  assign wasid    = rasid_q[{wr_ring, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rasid_q <= RASID_RESET;
      for (int s = 0; s < NSLOT; s++) begin
        vpn_q[s]  <= '0;
        ppn_q[s]  <= '0;
        asid_q[s] <= '0;
        attr_q[s] <= '0;
      end
    end else begin
      if (rasid_we) rasid_q <= {rasid_wdata[31:8], 8'h01};
      if (wsel_ok) begin
        vpn_q[wslot]  <= wr_sel[31:PAGE_SHIFT];
        ppn_q[wslot]  <= wr_ppn;
        asid_q[wslot] <= wasid;
        attr_q[wslot] <= wr_attr;
      end
    end
  end

  // lookup side
  logic [IDX_W-1:0]  lk_idx;
  logic [VPN_W-1:0]  lk_vpn;
  logic [NWAYS-1:0]  hit_vec;
  logic [WAY_W-1:0]  hit_way;
  logic              hit_any;
  logic              hit_multi;
  logic [SLOT_W-1:0] sel_slot;
  logic [7:0]        sel_asid;
  logic [1:0]        ring;

  assign lk_idx = lk_va[PAGE_SHIFT +: IDX_W];
  assign lk_vpn = lk_va[31:PAGE_SHIFT];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [SLOT_W-1:0] slot;
    assign slot       = {lk_data, WAY_W'(w), lk_idx};
    assign hit_vec[w] = (asid_q[slot] != 8'h00) && (vpn_q[slot] == lk_vpn);
  end

  always_comb begin
    hit_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign hit_any   = |hit_vec;
  assign hit_multi = (hit_vec & (hit_vec - 1'b1)) != '0;
  assign sel_slot  = {lk_data, hit_way, lk_idx};
  assign sel_asid  = asid_q[sel_slot];

  always_comb begin
    ring = 2'd3;
    for (int r = 3; r >= 0; r--)
      if (rasid_q[8*r +: 8] == sel_asid) ring = 2'(r);
  end

  assign lk_cause = !hit_any  ? {lk_data, 2'b01} :
                    hit_multi ? {lk_data, 2'b10} : 3'b000;
  assign lk_way   = hit_any ? 4'(hit_way)       : 4'd0;
  assign lk_index = hit_any ? lk_idx            : '0;
  assign lk_ring  = hit_any ? ring              : 2'd0;
  assign lk_ppn   = hit_any ? ppn_q[sel_slot]   : '0;
  assign lk_attr  = hit_any ? attr_q[sel_slot]  : 4'd0;

  // checks
  assert_rasid_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rasid_we |=> rasid_q == {$past(rasid_wdata[31:8]), 8'h01});

  assert_zero_asid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cause[1:0] != 2'b01 |-> sel_asid != 8'h00);

  assert_ring_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_cause[1:0] != 2'b01 && lk_ring != 2'd3) |-> rasid_q[{lk_ring, 3'b000} +: 8] == sel_asid);

  assert_multi_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) > 1 |-> lk_cause[1:0] == 2'b10);

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cause[1:0] == 2'b01 |-> (lk_way == 4'd0 && lk_ring == 2'd0 && lk_attr == 4'd0));

  assert_cause_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cause != 3'b000 |-> lk_cause[2] == lk_data);

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wsel_ok |=> asid_q[$past(wslot)] == $past(wasid));

endmodule

// File: tb/asid_tlb_lookup_tb.sv
`timescale 1ns/1ps
module asid_tlb_lookup_tb;
  localparam int NW = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_va = 0;
  logic        lk_data = 0;
  logic [3:0]  lk_way;
  logic [1:0]  lk_index;
  logic [1:0]  lk_ring;
  logic [2:0]  lk_cause;
  logic [19:0] lk_ppn;
  logic [3:0]  lk_attr;
  logic        wr_en = 0, wr_data = 0, rasid_we = 0;
  logic [31:0] wr_sel = 0, rasid_wdata = 0;
  logic [19:0] wr_ppn = 0;
  logic [1:0]  wr_ring = 0;
  logic [3:0]  wr_attr = 0;

  always #2.5 clk = ~clk;

  asid_tlb_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_data(lk_data),
    .lk_way(lk_way), .lk_index(lk_index), .lk_ring(lk_ring), .lk_cause(lk_cause),
    .lk_ppn(lk_ppn), .lk_attr(lk_attr), .wr_en(wr_en), .wr_data(wr_data),
    .wr_sel(wr_sel), .wr_ppn(wr_ppn), .wr_ring(wr_ring), .wr_attr(wr_attr),
    .rasid_we(rasid_we), .rasid_wdata(rasid_wdata));

  // reference model
  logic [19:0] m_vpn  [2][NW][4];
  logic [19:0] m_ppn  [2][NW][4];
  logic [7:0]  m_asid [2][NW][4];
  logic [3:0]  m_attr [2][NW][4];
  logic [31:0] m_rasid;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic model_reset();
    m_rasid = 32'h0403_0201;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NW; w++)
        for (int i = 0; i < 4; i++) begin
          m_vpn[s][w][i] = 0; m_ppn[s][w][i] = 0;
          m_asid[s][w][i] = 0; m_attr[s][w][i] = 0;
        end
  endtask

  function automatic logic [1:0] exp_ring(logic [7:0] a);
    for (int r = 0; r < 4; r++)
      if (m_rasid[8*r +: 8] == a) return 2'(r);
    return 2'd3;
  endfunction

  task automatic do_write(bit d, logic [31:0] sel, logic [19:0] ppn, logic [1:0] rg, logic [3:0] at);
    int w;
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_sel = sel; wr_ppn = ppn; wr_ring = rg; wr_attr = at;
    @(posedge clk); #1;
    wr_en = 0;
    w = d ? int'(sel[3:0]) : int'(sel[2:0]);
    if (w < NW) begin
      m_vpn[d][w][sel[13:12]]  = sel[31:12];
      m_ppn[d][w][sel[13:12]]  = ppn;
      m_asid[d][w][sel[13:12]] = m_rasid[8*rg +: 8];
      m_attr[d][w][sel[13:12]] = at;
    end
  endtask

  task automatic do_rasid(logic [31:0] v);
    @(negedge clk);
    rasid_we = 1; rasid_wdata = v;
    @(posedge clk); #1;
    rasid_we = 0;
    m_rasid = {v[31:8], 8'h01};
  endtask

  task automatic look(bit d, logic [31:0] va, string tag);
    logic [3:0] ew; logic [1:0] ei, er; logic [2:0] ec; logic [19:0] ep; logic [3:0] ea;
    int nh, fw;
    @(negedge clk);
    lk_data = d; lk_va = va;
    #1;
    nh = 0; fw = -1;
    for (int w = 0; w < NW; w++)
      if (m_asid[d][w][va[13:12]] != 0 && m_vpn[d][w][va[13:12]] == va[31:12]) begin
        nh++;
        if (fw < 0) fw = w;
      end
    if (nh == 0) begin
      ew = 0; ei = 0; er = 0; ep = 0; ea = 0; ec = {d, 2'b01};
    end else begin
      ew = 4'(fw); ei = va[13:12];
      er = exp_ring(m_asid[d][fw][va[13:12]]);
      ep = m_ppn[d][fw][va[13:12]]; ea = m_attr[d][fw][va[13:12]];
      ec = (nh > 1) ? {d, 2'b10} : 3'b000;
    end
    n_checks++;
    if ({lk_way, lk_index, lk_ring, lk_cause, lk_ppn, lk_attr} !== {ew, ei, er, ec, ep, ea}) begin
      n_fail++;
      $display("FAIL %s va=%h d=%0d: got way=%0d idx=%0d ring=%0d cause=%0d ppn=%h attr=%h, expected way=%0d idx=%0d ring=%0d cause=%0d ppn=%h attr=%h",
               tag, va, d, lk_way, lk_index, lk_ring, lk_cause, lk_ppn, lk_attr, ew, ei, er, ec, ep, ea);
    end
  endtask

  function automatic logic [7:0] pick_byte();
    case ($urandom % 6)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02;
      3: return 8'h03; 4: return 8'h04; default: return 8'h07;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 R7: after reset all lookups miss
    look(0, 32'h1234_5000, "R1_reset_miss_i");
    look(1, 32'h0000_0000, "R1_reset_miss_d");
    // R1 R5: reset ring map, ring k -> asid k+1
    for (int k = 0; k < 4; k++)
      do_write(1, {16'hA000, 4'(k), 8'h00, 4'(k)}, 20'h100 + 20'(k), 2'(k), 4'(k));
    for (int k = 0; k < 4; k++)
      look(1, {16'hA000, 4'(k), 12'h3FF}, "R1_R4_reset_ring");
    // R10: written entry visible the next cycle
    do_write(0, {20'hBEEF1, 8'h00, 4'h1}, 20'h5A5A5, 2'd0, 4'hC);
    look(0, 32'hBEEF_1ABC, "R10_next_cycle");
    // R11: other side unaffected
    look(1, 32'hBEEF_1ABC, "R11_side_separate");
    // R6 R8: multi-hit on instruction side, lowest way reported
    do_write(0, {20'hBEEF1, 8'h00, 4'h3}, 20'h11111, 2'd1, 4'h3);
    look(0, 32'hBEEF_1000, "R6_multi_i");
    // R9: data way 9 is ignored
    do_write(1, {20'hCAFE2, 8'h00, 4'h9}, 20'h22222, 2'd0, 4'h2);
    look(1, 32'hCAFE_2000, "R9_way_ignored");
    // R9: instruction write with bit3 set uses way 2
    do_write(0, {20'hCAFE2, 8'h00, 4'hA}, 20'h33333, 2'd0, 4'h7);
    look(0, 32'hCAFE_2000, "R9_ibit3_ignored");
    // R2: written low byte 0 is forced to 1, ring 0 entry stays valid
    do_rasid(32'h0A0B_0C00);
    do_write(1, {20'hD00D3, 8'h00, 4'h2}, 20'h44444, 2'd0, 4'h1);
    look(1, 32'hD00D_3000, "R2_low_byte_forced");
    // R5: no byte matches -> ring 3 (entries written with asid 2..4 earlier)
    look(1, {16'hA000, 4'd1, 12'h000}, "R5_no_match_ring3");
    // R5: duplicate bytes -> lowest ring
    do_rasid(32'h0202_0201);
    look(1, {16'hA000, 4'd1, 12'h000}, "R5_lowest_ring");
    // R3: asid 0 entry never hits
    do_rasid(32'h0000_0001);
    do_write(1, {20'hE00E0, 8'h00, 4'h1}, 20'h55555, 2'd2, 4'h5);
    look(1, 32'hE00E_0000, "R3_asid_zero");
    // R8: data-side multi-hit code
    do_rasid(32'h0403_0201);
    do_write(1, {20'hF00F1, 8'h00, 4'h0}, 20'h66666, 2'd1, 4'h6);
    do_write(1, {20'hF00F1, 8'h00, 4'h2}, 20'h77777, 2'd3, 4'h8);
    look(1, 32'hF00F_1000, "R8_R6_multi_d");

    // constrained random: R4 R5 R6 R7 R9 R10 R11
    for (int n = 0; n < 1500; n++) begin
      int op;
      bit d;
      logic [3:0] pg;
      op = $urandom % 10;
      d = 1'($urandom);
      pg = 4'($urandom);
      if (op < 3) begin
        logic [3:0] wy;
        wy = d ? 4'($urandom % 6) : {1'($urandom), 3'($urandom % 6)};
        do_write(d, {16'hC0DE, pg, 8'($urandom), wy}, 20'($urandom), 2'($urandom), 4'($urandom));
      end else if (op == 3) begin
        do_rasid({pick_byte(), pick_byte(), pick_byte(), 8'($urandom)});
      end else begin
        look(d, {16'hC0DE, pg, 12'($urandom)}, "R4_R5_R6_R7_random");
      end
    end

    // R1: reset clears everything again
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    model_reset();
    look(0, 32'hBEEF_1000, "R1_rereset_miss");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule